// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block deserializes two serial audio data lines that share one bit clock and one frame clock. Each frame carries a left and a right half. All of the serial inputs are sampled in the system clock domain, passed through synchronizers and turned into per-bit strobes. The block does not receive the serial clocks as clocks.

A 3-bit format code selects the framing. The choices are right-justified words of 16, 18, 20 or 24 bits, an I2S framing in which the word starts one bit after the frame clock changes, and a left-justified framing in which the word starts as the frame clock changes. The code is captured once, on the first system clock after reset is released.

For every complete frame the block presents three signed 24-bit words and a one-cycle valid strobe: left and right from the first line, and left from the second line. Shorter words are placed in the upper bits and padded with zeros below. The right half of the second line is dropped.

Top module: `aud_serial_rx`

## Requirements
- R1: The format code is captured on the first system clock after reset is released. Changes to it while reset stays released have no effect on decoding. The codes are: 000 = right-justified 16-bit, 001 = right-justified 18-bit, 010 = right-justified 20-bit, 011 = right-justified 24-bit, 100 = I2S, 101 = left-justified.
- R2: Left-justified mode (101):
  - A frame clock of 1 marks the left half and 0 marks the right half.
  - The MSB is the bit sampled together with the first frame clock value of a half.
  - Bits after the 24th of a half are ignored.
- R3: I2S mode (100):
  - A frame clock of 0 marks the left half and 1 marks the right half.
  - The MSB is the bit sampled one bit clock after the frame clock change.
  - Bits after the 24th are ignored.
- R4: Right-justified modes (000 to 011):
  - A frame clock of 1 marks the left half.
  - The word is the last N bits of the half, and its LSB is the last bit before the frame clock changes.
  - Earlier bits are ignored.
  - The N-bit word appears in output bits 23 down to 24-N, with zeros below.
- R5: In the left-justified and I2S modes, a half-frame of 16 bits yields its 16 bits in output bits 23..8, with bits 7..0 zero.
- R6: The second data line yields only its left word. Its right-half bits never reach any output.
- R7: `out_valid` pulses for one cycle after the right half of each complete frame ends. The three words change only in that cycle. A frame that is already under way when reset is released produces no pulse.
- R8: A reserved format code (110 or 111) drives `fmt_err` high. The words then stay zero and `out_valid` stays low.
- R9: While reset is asserted and afterwards until the first frame completes, the following outputs are zero: all words, `out_valid`, and `fmt_err` for a legal code.
- R10: Bit-clock ratios of 32, 48 and 64 bits per frame are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_sel | input | 3 | Framing code, captured on reset release |
| bclk_in | input | 1 | Serial bit clock; data is taken on its rising edge |
| fclk_in | input | 1 | Frame clock selecting left or right half |
| sd0_in | input | 1 | First serial data line, stereo |
| sd1_in | input | 1 | Second serial data line, left half used |
| out_left0 | output | 24 | Left word of the first line |
| out_right0 | output | 24 | Right word of the first line |
| out_left1 | output | 24 | Left word of the second line |
| out_valid | output | 1 | One-cycle strobe marking a new set of words |
| fmt_err | output | 1 | High when the captured format code is reserved |

## Verification
Most internal faults in this block show up at the ports within one frame of being triggered:
- A wrong captured format, a wrong idea of which frame-clock level means left, or a bit counter off by one shifts or swaps the words.
- These faults appear as words shifted by one bit or channels swapped at the next `out_valid`, one frame after the stimulus.
- A wrong boundary decision in the I2S delayed framing moves the LSB into the next word, which shows up as a wrong value in bit 0 or bit 23.
- A bad pending-left flag shows as a missing or doubled strobe, or as a pulse from the partial frame after reset.

The directed cases therefore fill the ignored bit positions with ones, so that masking faults change the visible value. Each case counts the strobes as well as comparing the words.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;
  localparam int RJB_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'b000,
    FMT_RJ18 = 3'b001,
    FMT_RJ20 = 3'b010,
    FMT_RJ24 = 3'b011,
    FMT_I2S  = 3'b100,
    FMT_LJ   = 3'b101,
    FMT_RSV6 = 3'b110,
    FMT_RSV7 = 3'b111
  } fmt_e;

  typedef struct packed {
    logic             legal;      // code is usable
    logic             delayed;    // word starts one bit after the frame edge
    logic             left_high;  // frame clock high marks the left half
    logic             tail_align; // word is the last bits of the half
    logic [RJB_W-1:0] rj_bits;    // word length when tail aligned
  } fmt_cfg_t;

  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
    fmt_cfg_t c;
    c.legal      = 1'b1;
    c.delayed    = 1'b0;
    c.left_high  = 1'b1;
    c.tail_align = 1'b0;
    c.rj_bits    = RJB_W'(SAMPLE_W);
    case (fmt_e'(code))
      FMT_RJ16: begin c.tail_align = 1'b1; c.rj_bits = RJB_W'(16); end
      FMT_RJ18: begin c.tail_align = 1'b1; c.rj_bits = RJB_W'(18); end
      FMT_RJ20: begin c.tail_align = 1'b1; c.rj_bits = RJB_W'(20); end
      FMT_RJ24: begin c.tail_align = 1'b1; c.rj_bits = RJB_W'(24); end
      FMT_I2S:  begin c.delayed = 1'b1; c.left_high = 1'b0; end
      FMT_LJ:   ;
      default:  c.legal = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/aud_pin_sync.sv
module aud_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         clk_rise  // rising edge of bit 0 after synchronization
);

  logic [W-1:0] stg [STAGES];
  logic         last0_q;

  // Reset high so an idle-high bit clock gives no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last0_q <= 1'b1;
    else        last0_q <= stg[STAGES-1][0];
  end

  assign q        = stg[STAGES-1];
  assign clk_rise = stg[STAGES-1][0] & ~last0_q;

  // A rising edge cannot be seen on two consecutive system clocks
  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> !clk_rise);

endmodule

// File: rtl/aud_slot_ctrl.sv
module aud_slot_ctrl
  import aud_rx_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_cfg_t         cfg,
  input  logic             bit_stb,
  input  logic             lr_bit,
  output logic             slot_start,  // current bit opens a new half
  output logic             slot_end,    // a fully received half just closed
  output logic             ended_left,  // the closed half was the left one
  output logic [POS_W-1:0] bit_pos      // position of the current bit in its half
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             lr_p1_q, lr_p2_q, lr_p1_d, lr_p2_d;
  logic [1:0]       primed_q, primed_d;
  logic [POS_W-1:0] cnt_q, cnt_d;
  logic             synced_q, synced_d;
  logic             edge_now, ended_lr;

  always_comb begin
    if (cfg.delayed) begin
      edge_now = (lr_p1_q != lr_p2_q) && (primed_q >= 2'd2);
      ended_lr = lr_p2_q;
    end else begin
      edge_now = (lr_bit != lr_p1_q) && (primed_q >= 2'd1);
      ended_lr = lr_p1_q;
    end
    ended_left = cfg.left_high ? ended_lr : ~ended_lr;

    lr_p1_d  = lr_p1_q;
    lr_p2_d  = lr_p2_q;
    primed_d = primed_q;
    cnt_d    = cnt_q;
    synced_d = synced_q;
    if (bit_stb) begin
      lr_p1_d  = lr_bit;
      lr_p2_d  = lr_p1_q;
      primed_d = (primed_q == 2'd3) ? primed_q : primed_q + 2'd1;
      if (edge_now)              cnt_d = '0;
      else if (cnt_q != POS_MAX) cnt_d = cnt_q + 1'b1;
      if (edge_now)              synced_d = 1'b1;
    end
    bit_pos    = cnt_d;
    slot_start = bit_stb & edge_now;
    slot_end   = bit_stb & edge_now & synced_q & cfg.legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_p1_q  <= 1'b0;
      lr_p2_q  <= 1'b0;
      primed_q <= '0;
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      lr_p1_q  <= lr_p1_d;
      lr_p2_q  <= lr_p2_d;
      primed_q <= primed_d;
      cnt_q    <= cnt_d;
      synced_q <= synced_d;
    end
  end

endmodule

// File: rtl/aud_lane_capture.sv
module aud_lane_capture
  import aud_rx_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fmt_cfg_t            cfg,
  input  logic                bit_stb,
  input  logic                slot_start,
  input  logic [POS_W-1:0]    bit_pos,
  input  logic                sd_bit,
  output logic [SAMPLE_W-1:0] word   // word of the half that closes on slot_start
);

  logic [SAMPLE_W-1:0] hist_q, hist_d;
  logic [SAMPLE_W-1:0] acc_q, acc_d;
  logic [RJB_W-1:0]    lead_sh;

  always_comb begin
    hist_d = hist_q;
    acc_d  = acc_q;
    if (bit_stb) begin
      hist_d = {hist_q[SAMPLE_W-2:0], sd_bit};
      if (slot_start) acc_d = '0;
      for (int i = 0; i < SAMPLE_W; i++) begin
        if (bit_pos == POS_W'(SAMPLE_W - 1 - i)) acc_d[i] = sd_bit;
      end
    end
    lead_sh = RJB_W'(SAMPLE_W) - cfg.rj_bits;
    word    = cfg.tail_align ? (hist_q << lead_sh) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      acc_q  <= '0;
    end else begin
      hist_q <= hist_d;
      acc_q  <= acc_d;
    end
  end

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MAX_HALF_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic                bclk_in,
  input  logic                fclk_in,
  input  logic                sd0_in,
  input  logic                sd1_in,
  output logic [SAMPLE_W-1:0] out_left0,
  output logic [SAMPLE_W-1:0] out_right0,
  output logic [SAMPLE_W-1:0] out_left1,
  output logic                out_valid,
  output logic                fmt_err
);

  localparam int POS_W   = $clog2(MAX_HALF_BITS + 1);
  localparam int N_LANES = 2;

  // Reset: asserted at once, released on the clock
  logic rst_m_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q   <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_m_q   <= 1'b1;
      rst_int_n <= rst_m_q;
    end
  end

  // Format capture on the first clock out of reset
  logic [2:0] fmt_q, fmt_d;
  logic       cfg_done_q, cfg_done_d;
  fmt_cfg_t   cfg;

  always_comb begin
    fmt_d      = fmt_q;
    cfg_done_d = cfg_done_q;
    if (!cfg_done_q) begin
      fmt_d      = fmt_sel;
      cfg_done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fmt_q      <= '0;
      cfg_done_q <= 1'b0;
    end else begin
      fmt_q      <= fmt_d;
      cfg_done_q <= cfg_done_d;
    end
  end

  assign cfg     = decode_fmt(fmt_q);
  assign fmt_err = cfg_done_q & ~cfg.legal;

  // Input synchronization: bit 0 bit clock, 1 frame clock, 2..3 data
  logic [3:0] pins;
  logic       bit_stb;

  aud_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .din      ({sd1_in, sd0_in, fclk_in, bclk_in}),
    .q        (pins),
    .clk_rise (bit_stb)
  );

  logic             slot_start, slot_end, ended_left;
  logic [POS_W-1:0] bit_pos;

  aud_slot_ctrl #(.POS_W(POS_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg        (cfg),
    .bit_stb    (bit_stb),
    .lr_bit     (pins[1]),
    .slot_start (slot_start),
    .slot_end   (slot_end),
    .ended_left (ended_left),
    .bit_pos    (bit_pos)
  );

  logic [SAMPLE_W-1:0] lane_word [N_LANES];

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    aud_lane_capture #(.POS_W(POS_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .cfg        (cfg),
      .bit_stb    (bit_stb),
      .slot_start (slot_start),
      .bit_pos    (bit_pos),
      .sd_bit     (pins[2+l]),
      .word       (lane_word[l])
    );
  end

  // Frame assembly: hold the left words until the right half closes
  logic [SAMPLE_W-1:0] pend_l0_q, pend_l1_q, pend_l0_d, pend_l1_d;
  logic [SAMPLE_W-1:0] l0_q, r0_q, l1_q, l0_d, r0_d, l1_d;
  logic                have_left_q, have_left_d, valid_q, valid_d;

  always_comb begin
    pend_l0_d   = pend_l0_q;
    pend_l1_d   = pend_l1_q;
    have_left_d = have_left_q;
    l0_d        = l0_q;
    r0_d        = r0_q;
    l1_d        = l1_q;
    valid_d     = 1'b0;
    if (slot_end) begin
      if (ended_left) begin
        pend_l0_d   = lane_word[0];
        pend_l1_d   = lane_word[1];
        have_left_d = 1'b1;
      end else begin
        have_left_d = 1'b0;
        if (have_left_q) begin
          l0_d    = pend_l0_q;
          r0_d    = lane_word[0];
          l1_d    = pend_l1_q;
          valid_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_l0_q   <= '0;
      pend_l1_q   <= '0;
      have_left_q <= 1'b0;
      l0_q        <= '0;
      r0_q        <= '0;
      l1_q        <= '0;
      valid_q     <= 1'b0;
    end else begin
      pend_l0_q   <= pend_l0_d;
      pend_l1_q   <= pend_l1_d;
      have_left_q <= have_left_d;
      l0_q        <= l0_d;
      r0_q        <= r0_d;
      l1_q        <= l1_d;
      valid_q     <= valid_d;
    end
  end

  assign out_left0  = l0_q;
  assign out_right0 = r0_q;
  assign out_left1  = l1_q;
  assign out_valid  = valid_q;

  // Captured format never moves once taken
  assert_fmt_frozen_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_done_q |=> $stable(fmt_q));

  // Strobe lasts one cycle
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |=> !out_valid);

  // Words change only together with the strobe
  assert_hold_words_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$stable(out_left0) || !$stable(out_right0) || !$stable(out_left1)) |-> out_valid);

  // Reserved code: no strobe
  assert_rsv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    fmt_err |-> !out_valid);

  // Reserved code: words stay zero
  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    fmt_err |-> (out_left0 == '0 && out_right0 == '0 && out_left1 == '0));

endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  fmt_sel;
  logic        bclk_in, fclk_in, sd0_in, sd1_in;
  logic [23:0] out_left0, out_right0, out_left1;
  logic        out_valid, fmt_err;

  int n_checks = 0;
  int n_fail   = 0;
  int vcount   = 0;
  bit done     = 1'b0;
  logic [2:0] cur_fmt;

  always #4 clk = ~clk;

  aud_serial_rx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .bclk_in    (bclk_in),
    .fclk_in    (fclk_in),
    .sd0_in     (sd0_in),
    .sd1_in     (sd1_in),
    .out_left0  (out_left0),
    .out_right0 (out_right0),
    .out_left1  (out_left1),
    .out_valid  (out_valid),
    .fmt_err    (fmt_err)
  );

  always @(negedge clk) if (rst_n && out_valid) vcount++;

  task automatic chk(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int rj_len(input logic [2:0] f);
    case (f)
      3'b000: return 16;
      3'b001: return 18;
      3'b010: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] top_mask(input int n);
    return ~(24'hFFFFFF >> n);
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input int h, input logic [23:0] v);
    if (f <= 3'b011) return v & top_mask(rj_len(f));
    if (h >= 24)     return v;
    return v & top_mask(h);
  endfunction

  // Bit at position p of a half of h bits; unused positions carry ones
  function automatic logic slot_bit(input logic [2:0] f, input int h, input int p, input logic [23:0] w);
    int n;
    if (f <= 3'b011) begin
      n = rj_len(f);
      if (p >= h - n) return w[23 - (p - (h - n))];
      return 1'b1;
    end
    if (p < 24) return w[23 - p];
    return 1'b1;
  endfunction

  task automatic send_bit(input logic fc, input logic d0, input logic d1);
    @(negedge clk);
    bclk_in = 1'b0; fclk_in = fc; sd0_in = d0; sd1_in = d1;
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input int h, input logic [23:0] l0, input logic [23:0] r0,
                            input logic [23:0] l1, input logic [23:0] r1);
    for (int k = 0; k < 2 * h; k++) begin
      bit right = (k >= h);
      int p = k % h;
      logic fc;
      if (cur_fmt == 3'b100) fc = (((k + 1) % (2 * h)) >= h);
      else                   fc = ~right;
      send_bit(fc, slot_bit(cur_fmt, h, p, right ? r0 : l0),
                   slot_bit(cur_fmt, h, p, right ? r1 : l1));
    end
  endtask

  task automatic apply_reset(input logic [2:0] f);
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = f; cur_fmt = f;
    bclk_in = 1'b1; fclk_in = 1'b0; sd0_in = 1'b0; sd1_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // One scenario: warm-up frame, frame under test, trailing frame
  task automatic run_case(input string tag, input logic [2:0] f, input int h,
                          input logic [23:0] l0, input logic [23:0] r0,
                          input logic [23:0] l1, input logic [23:0] r1);
    int v0;
    apply_reset(f);
    v0 = vcount;
    send_frame(h, 24'h0, 24'h0, 24'h0, 24'h0);
    send_frame(h, l0, r0, l1, r1);
    send_frame(h, 24'h0, 24'h0, 24'h0, 24'h0);
    repeat (8) @(negedge clk);
    chk(tag, "left0",  out_left0,  expect_word(f, h, l0));
    chk(tag, "right0", out_right0, expect_word(f, h, r0));
    chk(tag, "left1",  out_left1,  expect_word(f, h, l1));
    chk("R7", {tag, " strobes"}, 24'(vcount - v0), 24'd1);
  endtask

  task automatic test_reset_state_r9();
    apply_reset(3'b101);
    chk("R9", "left0 at reset",  out_left0,  24'h0);
    chk("R9", "right0 at reset", out_right0, 24'h0);
    chk("R9", "left1 at reset",  out_left1,  24'h0);
    chk("R9", "valid at reset",  {23'h0, out_valid}, 24'h0);
    chk("R9", "fmt_err legal",   {23'h0, fmt_err},   24'h0);
  endtask

  task automatic test_late_code_r1();
    int v0;
    apply_reset(3'b101);
    fmt_sel = 3'b000;  // changed after capture: must be ignored
    v0 = vcount;
    send_frame(32, 24'h0, 24'h0, 24'h0, 24'h0);
    send_frame(32, 24'h13579B, 24'h2468AC, 24'h0F0F0F, 24'h0);
    send_frame(32, 24'h0, 24'h0, 24'h0, 24'h0);
    repeat (8) @(negedge clk);
    chk("R1", "left0 late code",  out_left0,  24'h13579B);
    chk("R1", "right0 late code", out_right0, 24'h2468AC);
    chk("R1", "strobes late code", 24'(vcount - v0), 24'd1);
  endtask

  task automatic test_reserved_r8(input logic [2:0] f);
    int v0;
    apply_reset(f);
    cur_fmt = 3'b101;
    v0 = vcount;
    chk("R8", "fmt_err set", {23'h0, fmt_err}, 24'h1);
    send_frame(32, 24'h0, 24'h0, 24'h0, 24'h0);
    send_frame(32, 24'h7FFFFF, 24'h800000, 24'h123456, 24'h0);
    send_frame(32, 24'h0, 24'h0, 24'h0, 24'h0);
    repeat (8) @(negedge clk);
    chk("R8", "left0 zero",  out_left0,  24'h0);
    chk("R8", "right0 zero", out_right0, 24'h0);
    chk("R8", "left1 zero",  out_left1,  24'h0);
    chk("R8", "no strobe",   24'(vcount - v0), 24'd0);
  endtask

  task automatic test_sub_right_r6();
    // Second line carries data only in its right half
    run_case("R6", 3'b101, 32, 24'h111111, 24'h222222, 24'h000000, 24'hFFFFFF);
    run_case("R6", 3'b100, 32, 24'h0, 24'h0, 24'h3C3C3C, 24'hC3C3C3);
  endtask

  initial begin
    rst_n = 1'b0; fmt_sel = 3'b101; cur_fmt = 3'b101;
    bclk_in = 1'b1; fclk_in = 1'b0; sd0_in = 1'b0; sd1_in = 1'b0;
    test_reset_state_r9();
    run_case("R2",  3'b101, 32, 24'h123456, 24'hABCDEF, 24'h5A5A5A, 24'hFFFFFF);
    run_case("R10", 3'b101, 24, 24'h800001, 24'h7FFFFE, 24'hC0FFEE, 24'h000000);
    run_case("R3",  3'b100, 32, 24'h123457, 24'hFEDCBA, 24'hA5A5A5, 24'h0F0F0F);
    run_case("R10", 3'b100, 24, 24'h800001, 24'h000001, 24'h400003, 24'hFFFFFF);
    run_case("R5",  3'b100, 16, 24'hBEEF12, 24'h1234FF, 24'h8001FF, 24'hFFFFFF);
    run_case("R5",  3'b101, 16, 24'h7ABCDE, 24'h8000AA, 24'hFFFF55, 24'h000000);
    run_case("R4",  3'b000, 32, 24'hABCD00, 24'h123400, 24'h800100, 24'hFFFF00);
    run_case("R4",  3'b001, 24, 24'hFFFFC0, 24'h4000C0, 24'h800040, 24'h000000);
    run_case("R4",  3'b010, 32, 24'h12345F, 24'h8000F0, 24'hFEDCBF, 24'hFFFFFF);
    run_case("R4",  3'b011, 32, 24'h800001, 24'h7FFFFF, 24'h000001, 24'hFFFFFF);
    run_case("R4",  3'b011, 24, 24'hA50F33, 24'h5AF0CC, 24'hFFFFFE, 24'h000000);
    test_sub_right_r6();
    test_late_code_r1();
    test_reserved_r8(3'b110);
    test_reserved_r8(3'b111);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule